// File: doc/BRIEF.md
# Long-Latency Bus Multiplier Unit

This block is a functional unit that sits on the shared data bus of a move-based processor, where every instruction is a transfer from one unit to another. Software moves two unsigned operands into the unit, and the move into the second operand starts a multiply. The multiply runs for a fixed number of clock cycles. The double-width product is then read back as two bus words, the low half and the high half. A status word reports whether a multiply is still running.

The multiply uses an unsigned shift-and-add scheme that folds in one multiplier bit per step. The total latency is a parameter that may be longer than the operand width, to fit a slower bus schedule. While the result is not ready, the unit holds the shared bus through its stall output. A mode input selects how it does this. In the first mode, the bus is frozen from the start of the multiply until the result is ready. In the second mode, other moves run freely, and the stall is raised only when a product word is read too early. This lets independent transfers overlap the multiply latency.

Top module: `mulfu_top`

## Requirements
- R1: After reset the status word reads 0, both product words read 0, and `stall` is low.
- R2: A write to select code 0 only loads operand A. It starts nothing, and the status word stays 0.
- R3: A write to select code 1 loads operand B and starts a multiply. The status word (select 4, bit 0) reads 1 in the LATENCY cycles that follow the write, then reads 0.
- R4: When the multiply ends, select 2 reads the low WIDTH bits and select 3 reads the high WIDTH bits of the unsigned product A*B. Select codes 5 to 7 read 0, and reads give 0 when `rd_en` is low.
- R5: With `stall_on_start` at 1, `stall` is high in each of the LATENCY cycles after the starting write. It falls in the same cycle that the status word returns to 0.
- R6: With `stall_on_start` at 0, `stall` is high only while a multiply runs and select 2 or 3 is being read. Status reads and operand writes during a multiply do not stall.
- R7: A write to operand B while a multiply runs restarts the multiply. The restart uses the current operand A and the new B, and the full LATENCY is counted again from that write.
- R8: A write to operand A while a multiply runs does not change that multiply's result. The multiply uses the A value held at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_on_start | input | 1 | 1: freeze the bus for the whole multiply; 0: stall only on early product reads |
| sel | input | 3 | Subunit select: 0 operand A, 1 operand B/start, 2 product low, 3 product high, 4 status |
| wr_en | input | 1 | Write strobe for the selected subunit |
| rd_en | input | 1 | Read strobe for the selected subunit |
| wdata | input | WIDTH | Bus write data |
| rdata | output | WIDTH | Bus read data |
| stall | output | 1 | Bus hold request |

## Verification
The bench builds the unit with its defaults: WIDTH 32 and LATENCY 64. This makes the latency twice the number of shift-and-add steps, so the idle hold at the end of each multiply is exercised as well as the arithmetic. Full 32-bit operands, including all ones, reach the top carry of the adder. Random read delays from zero to past 64 cycles cover stall lengths from the full window down to none.

// File: rtl/mulfu_pkg.sv
package mulfu_pkg;
  typedef enum logic [2:0] {
    SUB_OPA    = 3'd0,
    SUB_OPB    = 3'd1,
    SUB_PRODLO = 3'd2,
    SUB_PRODHI = 3'd3,
    SUB_STATUS = 3'd4
  } mulfu_sub_e;

  function automatic logic is_product_sel(input logic [2:0] s);
    return (s == SUB_PRODLO) || (s == SUB_PRODHI);
  endfunction
endpackage

// File: rtl/mulfu_regs.sv
module mulfu_regs
  import mulfu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] opa_q,
  output logic [WIDTH-1:0] opb_q,
  output logic             wr_a_evt,
  output logic             start_evt
);
  assign wr_a_evt  = wr_en && (sel == SUB_OPA);
  assign start_evt = wr_en && (sel == SUB_OPB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (wr_a_evt)  opa_q <= wdata;
      if (start_evt) opb_q <= wdata;
    end
  end

  assert_opa_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_evt |-> !start_evt);
endmodule

// File: rtl/mulfu_core.sv
module mulfu_core #(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   start_a,
  input  logic [WIDTH-1:0]   start_b,
  output logic               busy,
  output logic [2*WIDTH-1:0] product
);
  localparam int CNTW = $clog2(LATENCY + 1);
  localparam logic [CNTW-1:0] STEPS = CNTW'(WIDTH);
  localparam logic [CNTW-1:0] LAST  = CNTW'(LATENCY - 1);

  // One shift-and-add step: add the multiplicand to the upper half when the
  // current multiplier bit is set, then shift the whole product right.
  function automatic logic [2*WIDTH-1:0] mul_step(input logic [2*WIDTH-1:0] p,
                                                  input logic [WIDTH-1:0]   m);
    logic [WIDTH:0] sum;
    sum = {1'b0, p[2*WIDTH-1:WIDTH]} + (p[0] ? {1'b0, m} : '0);
    return {sum, p[WIDTH-1:1]};
  endfunction

  logic               busy_q;
  logic [CNTW-1:0]    cnt_q;
  logic [WIDTH-1:0]   mcand_q;
  logic [2*WIDTH-1:0] prod_q;
  logic               step_evt;
  logic               done_evt;

  assign step_evt = busy_q && !start && (cnt_q < STEPS);
  assign done_evt = busy_q && !start && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      mcand_q <= start_a;
      prod_q  <= {{WIDTH{1'b0}}, start_b};
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (step_evt) prod_q <= mul_step(prod_q, mcand_q);
      if (done_evt) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign product = prod_q;

  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == '0));
  assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
  assert_done_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy_q);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(prod_q));
  assert_mcand_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> $stable(mcand_q));
endmodule

// File: rtl/mulfu_stall.sv
module mulfu_stall
  import mulfu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall_on_start,
  input  logic       busy,
  input  logic       rd_en,
  input  logic [2:0] sel,
  output logic       stall
);
  logic early_read;

  assign early_read = busy && rd_en && is_product_sel(sel);
  assign stall      = stall_on_start ? busy : early_read;

  assert_stall_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);
  assert_start_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_on_start && busy) |-> stall);
  assert_read_mode_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_on_start && !(rd_en && is_product_sel(sel))) |-> !stall);
endmodule

// File: rtl/mulfu_top.sv
module mulfu_top
  import mulfu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_on_start,
  input  logic [2:0]       sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             stall
);
  logic [WIDTH-1:0]   opa_q;
  logic [WIDTH-1:0]   opb_q;
  logic               wr_a_evt;
  logic               start_evt;
  logic               busy;
  logic [2*WIDTH-1:0] product;
  logic [WIDTH-1:0]   read_mux;

  initial assert (LATENCY >= WIDTH);

  mulfu_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
    .opa_q(opa_q), .opb_q(opb_q), .wr_a_evt(wr_a_evt), .start_evt(start_evt)
  );

  mulfu_core #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .start_a(opa_q),
    .start_b(wdata), .busy(busy), .product(product)
  );

  mulfu_stall u_stall (
    .clk(clk), .rst_n(rst_n), .stall_on_start(stall_on_start), .busy(busy),
    .rd_en(rd_en), .sel(sel), .stall(stall)
  );

  always_comb begin
    unique case (sel)
      SUB_OPA:    read_mux = opa_q;
      SUB_OPB:    read_mux = opb_q;
      SUB_PRODLO: read_mux = product[WIDTH-1:0];
      SUB_PRODHI: read_mux = product[2*WIDTH-1:WIDTH];
      SUB_STATUS: read_mux = {{(WIDTH-1){1'b0}}, busy};
      default:    read_mux = '0;
    endcase
  end

  assign rdata = rd_en ? read_mux : '0;

  assert_status_tracks_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SUB_STATUS) |-> (rdata[0] == busy));
  assert_opa_write_keeps_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_evt && !busy) |=> !busy);
endmodule

// File: tb/mulfu_top_test.sv
module mulfu_top_test;
  localparam int W = 32;
  localparam int L = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_on_start = 1'b0;
  logic [2:0] sel = 3'd0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic stall;

  int checks = 0;
  int fails = 0;
  logic wr_stall;

  always #5 clk = ~clk;

  mulfu_top #(.WIDTH(W), .LATENCY(L)) uut (
    .clk(clk), .rst_n(rst_n), .stall_on_start(stall_on_start), .sel(sel),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .stall(stall)
  );

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] wa = {32'd0, a};
    logic [63:0] wb = {32'd0, b};
    return wa * wb;
  endfunction

  function automatic int exp_stalls(input int waited);
    return (waited >= L) ? 0 : L - waited;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Entry and exit on a falling edge.
  task automatic do_write(input logic [2:0] s, input logic [31:0] d);
    sel = s; wdata = d; wr_en = 1'b1;
    #2 wr_stall = stall;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] s, output logic [31:0] v, output int stalls);
    sel = s; rd_en = 1'b1; stalls = 0;
    #2;
    while (stall) begin
      stalls++;
      @(negedge clk);
      #2;
    end
    v = rdata;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_product(input string req, input logic [63:0] exp);
    logic [31:0] lo, hi;
    int st;
    do_read(3'd2, lo, st);
    do_read(3'd3, hi, st);
    chk(req, {hi, lo}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog expired actual 1 expected 0");
    summary();
  end

  initial begin
    logic [31:0] v, a, b, a2, b2;
    int st, n, ones;
    void'($urandom(32'd4711));
    idle(3);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 stall", {63'd0, stall}, 64'd0);
    do_read(3'd4, v, st); chk("R1 status", {32'd0, v}, 64'd0);
    do_read(3'd2, v, st); chk("R1 prodlo", {32'd0, v}, 64'd0);
    do_read(3'd3, v, st); chk("R1 prodhi", {32'd0, v}, 64'd0);

    // R2 operand A write starts nothing
    do_write(3'd0, 32'd5);
    do_read(3'd4, v, st); chk("R2 status after A", {32'd0, v}, 64'd0);

    // R5 stall-on-start mode, full window
    stall_on_start = 1'b1;
    do_write(3'd0, 32'h1234_5678);
    do_write(3'd1, 32'h9abc_def0);
    n = 0;
    #2;
    while (stall) begin n++; @(negedge clk); #2; end
    @(negedge clk);
    chk("R5 stall cycles", 64'(n), 64'(L));
    do_read(3'd4, v, st); chk("R5 status after", {32'd0, v}, 64'd0);
    read_product("R4 directed", ref_prod(32'h1234_5678, 32'h9abc_def0));

    // R3/R6 read mode: status polling never stalls, busy exactly L reads
    stall_on_start = 1'b0;
    do_write(3'd0, 32'hffff_ffff);
    do_write(3'd1, 32'hffff_ffff);
    ones = 0; n = 0;
    do begin
      do_read(3'd4, v, st);
      n += st;
      if (v[0]) ones++;
    end while (v[0]);
    chk("R3 busy length", 64'(ones), 64'(L));
    chk("R6 status read stalls", 64'(n), 64'd0);
    read_product("R4 all ones", ref_prod(32'hffff_ffff, 32'hffff_ffff));

    // R6 early read stalls for the remainder
    do_write(3'd0, 32'd0);
    do_write(3'd1, 32'hdead_beef);
    idle(10);
    do_read(3'd2, v, st);
    chk("R6 early read stalls", 64'(st), 64'(exp_stalls(10)));
    do_read(3'd3, v, st);
    chk("R4 zero operand hi", {32'd0, v}, 64'd0);

    // R8 A write mid-run has no effect; R6 no stall on it
    a = 32'h0000_beef; b = 32'h0001_0003; a2 = 32'h7777_1111;
    do_write(3'd0, a);
    do_write(3'd1, b);
    idle(5);
    do_write(3'd0, a2);
    chk("R6 A write stall", {63'd0, wr_stall}, 64'd0);
    do_read(3'd2, v, st);
    chk("R8 stall count", 64'(st), 64'(exp_stalls(6)));
    chk("R8 lo", {32'd0, v}, {32'd0, ref_prod(a, b)[31:0]});
    do_read(3'd3, v, st);
    chk("R8 hi", {32'd0, v}, {32'd0, ref_prod(a, b)[63:32]});

    // R7 restart while busy
    b = 32'h0000_0101; b2 = 32'hc001_d00d;
    do_write(3'd1, b);
    idle(20);
    do_write(3'd1, b2);
    do_read(3'd2, v, st);
    chk("R7 restart stalls", 64'(st), 64'(L));
    do_read(3'd3, v, st);
    chk("R7 restart hi", {32'd0, v}, {32'd0, ref_prod(a2, b2)[63:32]});
    do_read(3'd2, v, st);
    chk("R7 restart lo", {32'd0, v}, {32'd0, ref_prod(a2, b2)[31:0]});

    // R4 unused selects and idle rd_en
    do_read(3'd6, v, st); chk("R4 unused select", {32'd0, v}, 64'd0);
    #2 chk("R4 rdata without rd_en", {32'd0, rdata}, 64'd0);
    @(negedge clk);

    // Random: mixed modes and delays
    for (int i = 0; i < 40; i++) begin
      a = $urandom; b = $urandom;
      if (i % 5 == 0) a = 32'hffff_ffff;
      stall_on_start = (i % 3 == 0);
      do_write(3'd0, a);
      do_write(3'd1, b);
      if (stall_on_start) begin
        n = 0; #2;
        while (stall) begin n++; @(negedge clk); #2; end
        @(negedge clk);
        chk("R5 random stall", 64'(n), 64'(L));
      end else begin
        n = $urandom_range(0, L + 4);
        idle(n);
        do_read(3'd2, v, st);
        chk("R6 random stall", 64'(st), 64'(exp_stalls(n)));
      end
      read_product("R4 random", ref_prod(a, b));
    end

    summary();
  end
endmodule